// File: doc/BRIEF.md
# Sprite DMA Cycle Scheduler

This block is the horizontal and vertical timebase of a raster video controller. It counts the cycles of each scan line and the lines of each frame for one of four selectable timing models. From the cycle position it raises single-cycle strobes that tell the rest of the controller when to act. The sprite fetch engine receives a start strobe and an end strobe for each of eight sprites. The line logic is told when to open a bad-line fetch, when to update the sprite data counters and counter bases, when to run the sprite DMA, Y-expansion and display checks, and when to do vertical blanking housekeeping.

A raster-compare input is matched against the line counter. A one-cycle pulse marks every rising edge of equality, so an interrupt controller can latch it directly. Every output is registered and refers to the cycle value shown on `line_cycle` in the same clock.

Top module: `sprite_dma_sched`

## Requirements
- R1: `line_cycle` counts 0 up to L-1 and then returns to 0. L is 64 for `model_sel`=0, 65 for 1, 63 for 2 and 65 for 3.
- R2: `raster_line` advances by one in the clock where `line_cycle` returns to 0. After the last line it wraps to 0. The line counts per frame are 262, 263, 312 and 312 for `model_sel` 0 to 3.
- R3: While `rst` is high, `line_cycle` holds L-1, `raster_line` holds the last line of the frame, and every strobe and `raster_match` is low. The first clock after release shows cycle 0 of line 0.
- R4: Bit i of `spr_dma_start` fires at these cycles. In the 63-cycle model, sprites 0 to 7 start at cycles 54, 56, 58, 60, 62, 1, 3 and 5. In the 64-cycle model they start at 55, 57, 59, 61, 63, 1, 3 and 5. In both 65-cycle models they start at 55, 57, 59, 61, 63, 0, 2 and 4.
- R5: Bit i of `spr_dma_end` fires five cycles after that sprite's start, taken modulo L. For example, in the 63-cycle model sprite 2 ends at cycle 0, and in the 65-cycle models sprite 3 ends at cycle 1.
- R6: Bit i of both `spr_dma_start` and `spr_dma_end` is suppressed in every clock where bit i of `spr_dma_en` is 0.
- R7: In every model, `vblank_chk` fires at cycle 0, `vblank_upd` at cycle 1, `badline_start` at 11, `mc_upd` at 14 and `mcbase_upd` at 15.
- R8: `dma_chk` fires on cycles 54 and 55 in the 63-cycle model and on cycles 55 and 56 in the other models. `yexp_chk` fires at cycle 55 in every model.
- R9: `disp_chk` fires at cycle 57 for `model_sel` 0 and 2, and at cycle 58 for `model_sel` 1 and 3.
- R10: `raster_match` is a single-cycle pulse in the first clock where `raster_line` equals the `raster_cmp` value sampled at the preceding edge, after a clock where it did not. A compare value changed to the current line also produces a pulse. A compare value beyond the last line never produces one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| model_sel | input | 2 | Timing model select, 0 to 3 |
| spr_dma_en | input | 8 | Per-sprite DMA active mask |
| raster_cmp | input | 9 | Raster compare line |
| line_cycle | output | 7 | Cycle within the current line |
| raster_line | output | 9 | Current raster line |
| spr_dma_start | output | 8 | Per-sprite DMA start strobes |
| spr_dma_end | output | 8 | Per-sprite DMA end strobes |
| vblank_chk | output | 1 | Vertical blank check strobe |
| vblank_upd | output | 1 | Vertical blank update strobe |
| badline_start | output | 1 | Bad-line fetch start strobe |
| mc_upd | output | 1 | Sprite data counter update strobe |
| mcbase_upd | output | 1 | Sprite counter base update strobe |
| dma_chk | output | 1 | Sprite DMA check strobe |
| yexp_chk | output | 1 | Sprite Y-expansion check strobe |
| disp_chk | output | 1 | Sprite display check strobe |
| raster_match | output | 1 | Raster compare rising-edge pulse |

## Verification
A wrong cycle or line counter shows at once on `line_cycle` or `raster_line`. Because every strobe is decoded from the same next-cycle value, the strobes then drift as well, one line later at the latest. A bad start or end decode shows up as a misplaced strobe the first time the affected sprite's window comes round, so at most one line after reset or after a mask change. A wrong compare edge detector shows within one line of a compare change: the pulse is missing, doubled or held high. A wrong line wrap shows at the end of the first frame.

// File: rtl/sprite_dma_sched_pkg.sv
package sprite_dma_sched_pkg;

  typedef enum logic [1:0] {
    MDL_OLD64  = 2'd0,
    MDL_NEW65  = 2'd1,
    MDL_PAL63  = 2'd2,
    MDL_PALN65 = 2'd3
  } model_e;

  // Cycles in one scan line.
  function automatic int cyc_per_line(logic [1:0] m);
    case (model_e'(m))
      MDL_OLD64: return 64;
      MDL_PAL63: return 63;
      default:   return 65;
    endcase
  endfunction

  // Lines in one frame.
  function automatic int lines_per_frame(logic [1:0] m);
    case (model_e'(m))
      MDL_OLD64: return 262;
      MDL_NEW65: return 263;
      default:   return 312;
    endcase
  endfunction

  // Cycle of sprite 0 DMA start (first of the two DMA check cycles).
  function automatic int spr0_start(logic [1:0] m);
    return (model_e'(m) == MDL_PAL63) ? 54 : 55;
  endfunction

  // Cycle of the sprite display check.
  function automatic int disp_cycle(logic [1:0] m);
    case (model_e'(m))
      MDL_NEW65, MDL_PALN65: return 58;
      default:               return 57;
    endcase
  endfunction

endpackage

// File: rtl/sprite_dma_sched_timebase.sv
module sprite_dma_sched_timebase
  import sprite_dma_sched_pkg::*;
#(
  parameter int CYC_W  = 7,
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        model_sel,
  output logic [CYC_W-1:0]  cyc_q,
  output logic [LINE_W-1:0] line_q,
  output logic [CYC_W-1:0]  cyc_nxt,
  output logic [LINE_W-1:0] line_nxt
);

  logic [CYC_W-1:0]  last_cyc;
  logic [LINE_W-1:0] last_line;

  assign last_cyc  = CYC_W'(cyc_per_line(model_sel) - 1);
  assign last_line = LINE_W'(lines_per_frame(model_sel) - 1);

  always_comb begin
    if (rst) begin
      cyc_nxt  = last_cyc;
      line_nxt = last_line;
    end else if (cyc_q >= last_cyc) begin
      cyc_nxt  = '0;
      line_nxt = (line_q >= last_line) ? '0 : line_q + 1'b1;
    end else begin
      cyc_nxt  = cyc_q + 1'b1;
      line_nxt = line_q;
    end
  end

  always_ff @(posedge clk) begin
    cyc_q  <= cyc_nxt;
    line_q <= line_nxt;
  end

  // R1
  cyc_range_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(model_sel) |-> (cyc_q <= last_cyc));

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_q != '0) |-> $stable(line_q));

endmodule

// File: rtl/sprite_dma_sched_decode.sv
module sprite_dma_sched_decode
  import sprite_dma_sched_pkg::*;
#(
  parameter int CYC_W   = 7,
  parameter int NUM_SPR = 8,
  parameter int SPR_GAP = 2,
  parameter int DMA_LEN = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         model_sel,
  input  logic [NUM_SPR-1:0] spr_en,
  input  logic [CYC_W-1:0]   cyc_nxt,
  output logic [NUM_SPR-1:0] spr_start,
  output logic [NUM_SPR-1:0] spr_end,
  output logic               vblank_chk,
  output logic               vblank_upd,
  output logic               badline_start,
  output logic               mc_upd,
  output logic               mcbase_upd,
  output logic               dma_chk,
  output logic               yexp_chk,
  output logic               disp_chk
);

  localparam int VBL_CHK_CYC = 0;
  localparam int VBL_UPD_CYC = 1;
  localparam int BADLINE_CYC = 11;
  localparam int MC_CYC      = 14;
  localparam int MCBASE_CYC  = 15;
  localparam int YEXP_CYC    = 55;

  int cpl;
  int base;
  int cn;
  logic [NUM_SPR-1:0] hit_start;
  logic [NUM_SPR-1:0] hit_end;

  assign cpl  = cyc_per_line(model_sel);
  assign base = spr0_start(model_sel);
  assign cn   = int'(cyc_nxt);

  for (genvar i = 0; i < NUM_SPR; i++) begin : g_spr
    int s_cyc;
    int e_cyc;
    assign s_cyc = (base + SPR_GAP * i) % cpl;
    assign e_cyc = (s_cyc + DMA_LEN) % cpl;
    assign hit_start[i] = (cn == s_cyc);
    assign hit_end[i]   = (cn == e_cyc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spr_start     <= '0;
      spr_end       <= '0;
      vblank_chk    <= 1'b0;
      vblank_upd    <= 1'b0;
      badline_start <= 1'b0;
      mc_upd        <= 1'b0;
      mcbase_upd    <= 1'b0;
      dma_chk       <= 1'b0;
      yexp_chk      <= 1'b0;
      disp_chk      <= 1'b0;
    end else begin
      spr_start     <= hit_start & spr_en;
      spr_end       <= hit_end & spr_en;
      vblank_chk    <= (cn == VBL_CHK_CYC);
      vblank_upd    <= (cn == VBL_UPD_CYC);
      badline_start <= (cn == BADLINE_CYC);
      mc_upd        <= (cn == MC_CYC);
      mcbase_upd    <= (cn == MCBASE_CYC);
      dma_chk       <= (cn == base) || (cn == base + 1);
      yexp_chk      <= (cn == YEXP_CYC);
      disp_chk      <= (cn == disp_cycle(model_sel));
    end
  end

  // R5
  start_end_apart_chk: assert property (@(posedge clk) disable iff (rst)
    (spr_start & spr_end) == '0);

  // R7
  fixed_strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vblank_chk, vblank_upd, badline_start, mc_upd, mcbase_upd}));

  // R8
  yexp_in_dma_chk: assert property (@(posedge clk) disable iff (rst)
    yexp_chk |-> dma_chk);

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(spr_start));

endmodule

// File: rtl/sprite_dma_sched.sv
module sprite_dma_sched
  import sprite_dma_sched_pkg::*;
#(
  parameter int CYC_W   = 7,
  parameter int LINE_W  = 9,
  parameter int NUM_SPR = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         model_sel,
  input  logic [NUM_SPR-1:0] spr_dma_en,
  input  logic [LINE_W-1:0]  raster_cmp,
  output logic [CYC_W-1:0]   line_cycle,
  output logic [LINE_W-1:0]  raster_line,
  output logic [NUM_SPR-1:0] spr_dma_start,
  output logic [NUM_SPR-1:0] spr_dma_end,
  output logic               vblank_chk,
  output logic               vblank_upd,
  output logic               badline_start,
  output logic               mc_upd,
  output logic               mcbase_upd,
  output logic               dma_chk,
  output logic               yexp_chk,
  output logic               disp_chk,
  output logic               raster_match
);

  logic [CYC_W-1:0]  cyc_nxt;
  logic [LINE_W-1:0] line_nxt;
  logic              cmp_eq_q;
  logic              cmp_eq_nxt;

  sprite_dma_sched_timebase #(
    .CYC_W  (CYC_W),
    .LINE_W (LINE_W)
  ) u_timebase (
    .clk       (clk),
    .rst       (rst),
    .model_sel (model_sel),
    .cyc_q     (line_cycle),
    .line_q    (raster_line),
    .cyc_nxt   (cyc_nxt),
    .line_nxt  (line_nxt)
  );

  sprite_dma_sched_decode #(
    .CYC_W   (CYC_W),
    .NUM_SPR (NUM_SPR)
  ) u_decode (
    .clk           (clk),
    .rst           (rst),
    .model_sel     (model_sel),
    .spr_en        (spr_dma_en),
    .cyc_nxt       (cyc_nxt),
    .spr_start     (spr_dma_start),
    .spr_end       (spr_dma_end),
    .vblank_chk    (vblank_chk),
    .vblank_upd    (vblank_upd),
    .badline_start (badline_start),
    .mc_upd        (mc_upd),
    .mcbase_upd    (mcbase_upd),
    .dma_chk       (dma_chk),
    .yexp_chk      (yexp_chk),
    .disp_chk      (disp_chk)
  );

  assign cmp_eq_nxt = (line_nxt == raster_cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_eq_q     <= 1'b0;
      raster_match <= 1'b0;
    end else begin
      cmp_eq_q     <= cmp_eq_nxt;
      raster_match <= cmp_eq_nxt & ~cmp_eq_q;
    end
  end

  // R10
  match_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    raster_match |=> !raster_match);

  // R3
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!raster_match && spr_dma_start == '0));

endmodule

// File: tb/sprite_dma_sched_bench.sv
module sprite_dma_sched_bench;

  localparam int NS = 8;

  typedef struct {
    int          cyc;
    int          line;
    logic [7:0]  st;
    logic [7:0]  en;
    logic [8:0]  fx;
    logic        m;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] model_sel = 2'd0;
  logic [7:0] spr_dma_en = 8'hFF;
  logic [8:0] raster_cmp = 9'd3;

  logic [6:0] line_cycle;
  logic [8:0] raster_line;
  logic [7:0] spr_dma_start, spr_dma_end;
  logic vblank_chk, vblank_upd, badline_start, mc_upd, mcbase_upd;
  logic dma_chk, yexp_chk, disp_chk, raster_match;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  exp_t q[$];

  int ecyc, eline;
  bit econd;

  always #2 clk = ~clk;

  sprite_dma_sched u_sprite_dma_sched (
    .clk(clk), .rst(rst), .model_sel(model_sel), .spr_dma_en(spr_dma_en),
    .raster_cmp(raster_cmp), .line_cycle(line_cycle), .raster_line(raster_line),
    .spr_dma_start(spr_dma_start), .spr_dma_end(spr_dma_end),
    .vblank_chk(vblank_chk), .vblank_upd(vblank_upd), .badline_start(badline_start),
    .mc_upd(mc_upd), .mcbase_upd(mcbase_upd), .dma_chk(dma_chk),
    .yexp_chk(yexp_chk), .disp_chk(disp_chk), .raster_match(raster_match)
  );

  function automatic int t_len(logic [1:0] m);
    return (m == 2'd0) ? 64 : (m == 2'd2) ? 63 : 65;
  endfunction

  function automatic int t_lines(logic [1:0] m);
    return (m == 2'd0) ? 262 : (m == 2'd1) ? 263 : 312;
  endfunction

  // R4 start table, written per line length
  function automatic int t_start(logic [1:0] m, int i);
    case (t_len(m))
      63:      return (i < 5) ? 54 + 2*i : 2*i - 9;
      64:      return (i < 5) ? 55 + 2*i : 2*i - 9;
      default: return (i < 5) ? 55 + 2*i : 2*i - 10;
    endcase
  endfunction

  // R5 end table
  function automatic int t_end(logic [1:0] m, int i);
    case (t_len(m))
      63:      return (i < 2) ? 59 + 2*i : 2*i - 4;
      64:      return (i < 2) ? 60 + 2*i : 2*i - 4;
      default: return (i < 3) ? 60 + 2*i : 2*i - 5;
    endcase
  endfunction

  // Driver: compute expected outputs for the edge just taken and queue them.
  task automatic push_expect();
    exp_t e;
    if (rst) begin
      ecyc = t_len(model_sel) - 1;
      eline = t_lines(model_sel) - 1;
      econd = 0;
      e.cyc = ecyc; e.line = eline; e.st = '0; e.en = '0; e.fx = '0; e.m = 1'b0;
    end else begin
      bit c;
      if (ecyc >= t_len(model_sel) - 1) begin
        ecyc = 0;
        eline = (eline >= t_lines(model_sel) - 1) ? 0 : eline + 1;
      end else ecyc = ecyc + 1;
      e.cyc = ecyc; e.line = eline;
      for (int i = 0; i < NS; i++) begin
        e.st[i] = (ecyc == t_start(model_sel, i)) && spr_dma_en[i];
        e.en[i] = (ecyc == t_end(model_sel, i)) && spr_dma_en[i];
      end
      e.fx[0] = (ecyc == 0);
      e.fx[1] = (ecyc == 1);
      e.fx[2] = (ecyc == 11);
      e.fx[3] = (ecyc == 14);
      e.fx[4] = (ecyc == 15);
      e.fx[5] = (model_sel == 2'd2) ? (ecyc == 54 || ecyc == 55) : (ecyc == 55 || ecyc == 56);
      e.fx[6] = (ecyc == 55);
      e.fx[7] = (model_sel[0]) ? (ecyc == 58) : (ecyc == 57);
      e.fx[8] = 1'b0;
      c = (eline == int'(raster_cmp));
      e.m = c && !econd;
      econd = c;
    end
    q.push_back(e);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      if (fails < 20) $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pop and compare away from the active edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [8:0] fx;
      e = q.pop_front();
      fx = {1'b0, disp_chk, yexp_chk, dma_chk, mcbase_upd, mc_upd, badline_start,
            vblank_upd, vblank_chk};
      chk(int'(line_cycle) == e.cyc, "R1/R3 cycle", int'(line_cycle), e.cyc);
      chk(int'(raster_line) == e.line, "R2/R3 line", int'(raster_line), e.line);
      chk(spr_dma_start == e.st, "R4/R6 start", int'(spr_dma_start), int'(e.st));
      chk(spr_dma_end == e.en, "R5/R6 end", int'(spr_dma_end), int'(e.en));
      chk(fx[4:0] == e.fx[4:0], "R7 fixed", int'(fx[4:0]), int'(e.fx[4:0]));
      chk(fx[7:5] == e.fx[7:5], "R8/R9 checks", int'(fx[7:5]), int'(e.fx[7:5]));
      chk(raster_match == e.m, "R10 match", int'(raster_match), int'(e.m));
    end
  end

  task automatic run_model(logic [1:0] m, logic [8:0] cmp0);
    int total;
    @(negedge clk);
    rst = 1'b1;
    model_sel = m;
    raster_cmp = cmp0;
    spr_dma_en = 8'hFF;
    repeat (3) begin
      @(posedge clk); #1; push_expect();
      @(negedge clk);
    end
    rst = 1'b0;
    total = t_len(m) * t_lines(m) + 3 * t_len(m);
    for (int n = 0; n < total; n++) begin
      @(posedge clk); #1; push_expect();
      @(negedge clk);
      // R6 mask patterns
      if (n == total / 4) spr_dma_en = 8'hA5;
      if (n == total / 2) spr_dma_en = 8'h00;
      if (n == (3 * total) / 4) spr_dma_en = 8'h5A;
      // R10 compare moved onto the current line mid-line
      if (n == total / 3) raster_cmp = 9'(eline);
      if (n == (2 * total) / 3) raster_cmp = 9'd400;
    end
  endtask

  initial begin
    run_model(2'd2, 9'd0);
    run_model(2'd1, 9'd262);
    run_model(2'd0, 9'd5);
    run_model(2'd3, 9'd311);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule